// File: doc/BRIEF.md
# FIFO Status Calendar Transmitter with Periodic Training

This block produces the transmit-side FIFO status stream of a SPI-4.2 style link. Once enabled it sends the same pattern again and again. It opens each calendar pass with a framing word and then sends one 2-bit status word for every calendar slot. Each slot word is the live FIFO status of the port named in that slot. The pass ends with a parity word. After a programmable number of complete passes it inserts a burst of training patterns. The burst holds a programmable count of patterns, and that count is one more than the programmed value.

Two calendars are held at the inputs, and either one may be selected. The select bit is honoured only while a separate switch-enable bit is set. A new selection is applied only where one pass ends and the next begins. Physical clocking, pads and data-path de-skew are not part of this block.

Top module: `fstat_cal_tx`

## Requirements
- R1: While `en` is 0, `stat_o` is 2'b11 and `sop_o` is 0 from the next clock on. The first cycle that `en` has been high at a clock edge produces a framing word.
- R2: Each pass begins with exactly one cycle of `stat_o` = 2'b11 with `sop_o` = 1, and `sop_o` is 0 in every other cycle.
- R3: After the framing word come `last+1` slot cycles, where `last` is the length field of the active calendar. In slot i, `stat_o` equals bits [2p+1:2p] of `fifo_stat`, where p is the value in bits [i*PW+PW-1:i*PW] of the active calendar's port vector.
- R4: The cycle after the last slot carries the parity word, which is the bitwise XOR of all slot words of that pass.
- R5: While `sw_en` is 0, calendar 0 is used whatever `cal_sel` holds.
- R6: While `sw_en` is 1, `cal_sel` = 0 picks calendar 0 and `cal_sel` = 1 picks calendar 1.
- R7: The calendar choice is sampled only on the clock edge that enters a framing word. A change to `sw_en` or `cal_sel` part-way through a pass does not affect that pass.
- R8: While `interval` is nonzero, completed passes are counted. When the count reaches `interval` at a parity word, a training burst follows that parity word, and the count restarts from zero.
- R9: A training burst consists of `alpha`+1 patterns. Each pattern is TRAIN_HALF cycles of 2'b00 followed by TRAIN_HALF cycles of 2'b11. A framing word follows the burst.
- R10: While `interval` is 0, no training is inserted and the pass count is held at zero. Passes then follow each other back to back, each `last`+3 cycles long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Status path enable |
| sw_en | input | 1 | Calendar switching enable |
| cal_sel | input | 1 | Calendar choice (0 or 1) |
| interval | input | CNT_W | Passes between training bursts, 0 disables training |
| alpha | input | ALPHA_W | Training repetitions minus one |
| fifo_stat | input | NPORTS*2 | Per-port 2-bit FIFO status, port p at [2p+1:2p] |
| cal0_ports | input | DEPTH*PW | Calendar 0 port numbers, slot i at [i*PW +: PW] |
| cal0_last | input | LW | Calendar 0 index of last slot |
| cal1_ports | input | DEPTH*PW | Calendar 1 port numbers |
| cal1_last | input | LW | Calendar 1 index of last slot |
| stat_o | output | 2 | Status bus |
| sop_o | output | 1 | High during the framing word of each pass |

## Verification
The bench builds the block with NPORTS=4, DEPTH=4 and TRAIN_HALF=10. With these values every calendar index, including the deepest slot, and every port number can be reached within short passes. Keeping the interval small, from 1 to 3, brings several training bursts and their pass-counter restarts into a run of a few thousand cycles. An alpha of 7 exercises a multi-pattern burst without long waits.

// File: rtl/fstat_cal_tx.sv
module fstat_cal_tx #(
  parameter int NPORTS     = 4,
  parameter int DEPTH      = 8,
  parameter int CNT_W      = 24,
  parameter int ALPHA_W    = 8,
  parameter int TRAIN_HALF = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   sw_en,
  input  logic                   cal_sel,
  input  logic [CNT_W-1:0]       interval,
  input  logic [ALPHA_W-1:0]     alpha,
  input  logic [NPORTS*2-1:0]    fifo_stat,
  input  logic [DEPTH*((NPORTS > 1) ? $clog2(NPORTS) : 1)-1:0] cal0_ports,
  input  logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0]         cal0_last,
  input  logic [DEPTH*((NPORTS > 1) ? $clog2(NPORTS) : 1)-1:0] cal1_ports,
  input  logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0]         cal1_last,
  output logic [1:0]             stat_o,
  output logic                   sop_o
);
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam int LW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int TW = $clog2(2*TRAIN_HALF);
  localparam logic [TW-1:0] T_HALF = TW'(TRAIN_HALF);
  localparam logic [TW-1:0] T_LAST = TW'(2*TRAIN_HALF - 1);

  localparam logic [2:0] S_IDLE  = 3'd0;
  localparam logic [2:0] S_FRAME = 3'd1;
  localparam logic [2:0] S_SLOT  = 3'd2;
  localparam logic [2:0] S_DIP   = 3'd3;
  localparam logic [2:0] S_TRAIN = 3'd4;

  logic [2:0]         st;
  logic               cal_q;
  logic [LW-1:0]      idx;
  logic [1:0]         acc;
  logic [CNT_W-1:0]   pcnt;
  logic [TW-1:0]      tcyc;
  logic [ALPHA_W-1:0] trep;

  logic [PW-1:0] slot_port;
  logic [LW-1:0] last_idx;
  logic [1:0]    slot_word;
  logic [CNT_W-1:0] pcnt_inc;
  logic          train_due;
  logic          cal_next;

  assign slot_port = cal_q ? cal1_ports[idx*PW +: PW] : cal0_ports[idx*PW +: PW];
  assign last_idx  = cal_q ? cal1_last : cal0_last;
  assign slot_word = fifo_stat[{slot_port, 1'b0} +: 2];
  assign pcnt_inc  = pcnt + 1'b1;
  assign train_due = (interval != '0) && (pcnt_inc >= interval);
  assign cal_next  = sw_en & cal_sel;

  always_comb begin
    case (st)
      S_SLOT:  stat_o = slot_word;
      S_DIP:   stat_o = acc;
      S_TRAIN: stat_o = (tcyc < T_HALF) ? 2'b00 : 2'b11;
      default: stat_o = 2'b11;
    endcase
  end

  assign sop_o = (st == S_FRAME);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cal_q <= 1'b0;
      idx   <= '0;
      acc   <= '0;
      pcnt  <= '0;
      tcyc  <= '0;
      trep  <= '0;
    end else if (!en) begin
      st   <= S_IDLE;
      pcnt <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          st    <= S_FRAME;
          cal_q <= cal_next;
        end
        S_FRAME: begin
          st  <= S_SLOT;
          idx <= '0;
          acc <= '0;
        end
        S_SLOT: begin
          acc <= acc ^ slot_word;
          if (idx == last_idx) st <= S_DIP;
          else idx <= idx + 1'b1;
        end
        S_DIP: begin
          if (interval == '0) begin
            pcnt  <= '0;
            st    <= S_FRAME;
            cal_q <= cal_next;
          end else if (train_due) begin
            pcnt <= '0;
            st   <= S_TRAIN;
            tcyc <= '0;
            trep <= '0;
          end else begin
            pcnt  <= pcnt_inc;
            st    <= S_FRAME;
            cal_q <= cal_next;
          end
        end
        S_TRAIN: begin
          if (tcyc == T_LAST) begin
            tcyc <= '0;
            if (trep == alpha) begin
              st    <= S_FRAME;
              cal_q <= cal_next;
            end else begin
              trep <= trep + 1'b1;
            end
          end else begin
            tcyc <= tcyc + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fstat_cal_tx_chk.sv
module fstat_cal_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       sw_en,
  input logic       cal_sel,
  input logic [1:0] stat_o,
  input logic       sop_o,
  input logic       cal_q,
  input logic [2:0] st
);
  localparam logic [2:0] C_FRAME = 3'd1;
  localparam logic [2:0] C_TRAIN = 3'd4;

  a_r1_idle_out: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (stat_o == 2'b11 && !sop_o));

  a_r2_sop_word: assert property (@(posedge clk) disable iff (!rst_n)
    sop_o |-> stat_o == 2'b11);

  a_r2_sop_single: assert property (@(posedge clk) disable iff (!rst_n)
    sop_o |=> !sop_o);

  a_r5_cal0_only: assert property (@(posedge clk) disable iff (!rst_n)
    (sop_o && !$past(sw_en)) |-> !cal_q);

  a_r6_sel_pick: assert property (@(posedge clk) disable iff (!rst_n)
    sop_o |-> (cal_q == ($past(sw_en) && $past(cal_sel))));

  a_r7_hold_in_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (st != C_FRAME) |-> $stable(cal_q));

  a_r9_train_word: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_TRAIN) |-> (stat_o == 2'b00 || stat_o == 2'b11) && !sop_o);
endmodule

bind fstat_cal_tx fstat_cal_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .sw_en(sw_en), .cal_sel(cal_sel),
  .stat_o(stat_o), .sop_o(sop_o), .cal_q(cal_q), .st(st)
);

// File: tb/fstat_cal_tx_tb.sv
`timescale 1ns/1ps
module fstat_cal_tx_tb;
  localparam int NP = 4, DP = 4, HALF = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, sw_en = 0, cal_sel = 0;
  logic [23:0] interval = '0;
  logic [7:0]  alpha = '0;
  logic [7:0]  fifo_stat = '0;
  logic [7:0]  cal0_ports, cal1_ports;
  logic [1:0]  cal0_last, cal1_last;
  logic [1:0]  stat_o;
  logic        sop_o;

  always #5 clk = ~clk;

  fstat_cal_tx #(.NPORTS(NP), .DEPTH(DP), .CNT_W(24), .ALPHA_W(8), .TRAIN_HALF(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .sw_en(sw_en), .cal_sel(cal_sel),
    .interval(interval), .alpha(alpha), .fifo_stat(fifo_stat),
    .cal0_ports(cal0_ports), .cal0_last(cal0_last),
    .cal1_ports(cal1_ports), .cal1_last(cal1_last),
    .stat_o(stat_o), .sop_o(sop_o));

  int total = 0, bad = 0;
  string scn = "R1";
  bit run_fifo = 0;

  // reference model state
  int ph = 0;  // 0 idle 1 frame 2 slot 3 parity 4 train
  int mcal = 0, midx = 0, macc = 0, mpc = 0, mt = 0, mr = 0;

  function automatic int port_of(int c, int i);
    return c ? int'(cal1_ports[i*2 +: 2]) : int'(cal0_ports[i*2 +: 2]);
  endfunction
  function automatic int last_of(int c);
    return c ? int'(cal1_last) : int'(cal0_last);
  endfunction
  function automatic int slot_val();
    int p;
    p = port_of(mcal, midx);
    return int'(fifo_stat[p*2 +: 2]);
  endfunction
  function automatic int exp_stat();
    case (ph)
      2: return slot_val();
      3: return macc;
      4: return (mt < HALF) ? 0 : 3;
      default: return 3;
    endcase
  endfunction
  function automatic string ph_tag();
    case (ph)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // per-cycle comparison and monitors
  int sop_cnt = 0, gap = 0, max_gap = 0;
  always @(negedge clk) if (rst_n) begin
    check({ph_tag(), " stat (scenario ", scn, ")"}, int'(stat_o), exp_stat());
    check({"R2 sop (scenario ", scn, ")"}, int'(sop_o), (ph == 1) ? 1 : 0);
    gap++;
    if (sop_o) begin
      sop_cnt++;
      if (gap > max_gap) max_gap = gap;
      gap = 0;
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; mcal = 0; midx = 0; macc = 0; mpc = 0; mt = 0; mr = 0;
    end else if (!en) begin
      ph = 0; mpc = 0;
    end else begin
      case (ph)
        0: begin ph = 1; mcal = sw_en && cal_sel; end
        1: begin ph = 2; midx = 0; macc = 0; end
        2: begin
          macc = macc ^ slot_val();
          if (midx == last_of(mcal)) ph = 3; else midx++;
        end
        3: begin
          if (interval == 0) begin mpc = 0; ph = 1; mcal = sw_en && cal_sel; end
          else begin
            mpc++;
            if (mpc >= int'(interval)) begin mpc = 0; ph = 4; mt = 0; mr = 0; end
            else begin ph = 1; mcal = sw_en && cal_sel; end
          end
        end
        default: begin
          if (mt == 2*HALF-1) begin
            mt = 0;
            if (mr == int'(alpha)) begin ph = 1; mcal = sw_en && cal_sel; end
            else mr++;
          end else mt++;
        end
      endcase
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      if (run_fifo) fifo_stat = 8'($urandom);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clr_mon();
    sop_cnt = 0; gap = 0; max_gap = 0;
  endtask

  bit finished = 0;
  initial begin
    #(10 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // calendar 0: last=2, slots ports 3,0,2 ; calendar 1: last=3, ports 1,1,0,3
    cal0_ports = {2'd0, 2'd2, 2'd0, 2'd3};
    cal0_last  = 2'd2;
    cal1_ports = {2'd3, 2'd0, 2'd1, 2'd1};
    cal1_last  = 2'd3;
    cyc(3);
    #2;
    check("R1 reset stat", int'(stat_o), 3);
    check("R1 reset sop", int'(sop_o), 0);
    rst_n = 1;
    cyc(4);
    check("R1 disabled stat", int'(stat_o), 3);

    // R10, R3, R4: no training, back-to-back passes of last+3 cycles
    scn = "R10";
    run_fifo = 1;
    en = 1;
    cyc(1);
    clr_mon();
    cyc(5 * 30);
    check("R10 pass count with interval 0", sop_cnt, 30);
    check("R10 longest gap", max_gap, 5);

    // R5: sel ignored while switching disabled
    scn = "R5";
    cal_sel = 1;
    clr_mon();
    cyc(100);
    check("R5 gap stays calendar 0 length", max_gap, 5);

    // R6: switching enabled picks calendar 1
    scn = "R6";
    sw_en = 1;
    cyc(12);
    clr_mon();
    cyc(120);
    check("R6 gap uses calendar 1 length", max_gap, 6);

    // R7: toggle selection mid-pass repeatedly
    scn = "R7";
    for (int k = 0; k < 40; k++) begin
      cyc(3 + (k % 4));
      cal_sel = ~cal_sel;
      if (k % 7 == 0) sw_en = ~sw_en;
    end
    sw_en = 1; cal_sel = 0;

    // R8, R9: periodic training
    scn = "R8";
    interval = 24'd2; alpha = 8'd0;
    cyc(12);
    clr_mon();
    cyc(300);
    check("R8 gap with one training pattern", max_gap, 5 + 2*HALF);
    scn = "R9";
    alpha = 8'd2;
    cyc(80);
    clr_mon();
    cyc(400);
    check("R9 gap with three training patterns", max_gap, 5 + 3*2*HALF);
    interval = 24'd1; alpha = 8'd7;
    cyc(1200);
    interval = 24'd3; alpha = 8'd1; cal_sel = 1;
    cyc(600);

    // R1: disable mid-pass then re-enable
    scn = "R1";
    en = 0;
    cyc(1);
    check("R1 idle after disable", int'(stat_o), 3);
    cyc(7);
    en = 1;
    cyc(1);
    check("R1 frame after enable", int'(sop_o), 1);
    cyc(200);

    // R10 again: interval cleared after training was active
    scn = "R10";
    interval = '0;
    cyc(60);
    clr_mon();
    cyc(180);
    check("R10 no training after clearing interval", max_gap, 6);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule